// File: doc/BRIEF.md
# PCI Interrupt Line Router

The block collects the four interrupt pins of several PCI devices, rotates each device's pins by its slot position, and merges the result onto four shared interrupt lines (A to D). Each shared line is then steered to one of sixteen legacy interrupt inputs, or to none. A legacy input is driven high while any shared line steered to it is high. Several lines may therefore share one input, and their levels are combined with a wired-OR.

Software programs the steering through four byte-wide routing registers. They sit on a small configuration port with a write strobe, a byte offset, write data and combinational read data. The legacy interrupt vector is registered. It follows any change of device pins or routing with one clock of latency.

Top module: `pci_intx_router`

## Requirements
- R1: Pin p (0 = first pin) of a device whose `dev_slot` field holds s, the slot number modulo 4, drives shared line (p + s + 3) mod 4, with line 0 = A up to 3 = D.
- R2: The routing registers for lines A, B, C and D are at offsets 0x60, 0x61, 0x62 and 0x63. A write with `cfg_wr` high stores `cfg_wdata` at the clock edge. `cfg_rdata` returns the register that `cfg_addr` selects. At any other offset a write changes nothing and a read returns 0x00.
- R3: A routing value from 0 to 15 steers its line to `irq_out` bit of that number. A value of 16 or more leaves the line unconnected, so it drives no output.
- R4: Each `irq_out` bit is the OR of the levels of every shared line whose routing register holds that bit's number.
- R5: With the default reset profile (`RESET_PROFILE` = 0), reset loads 0x80 into all four routing registers and clears `irq_out`. No device activity then reaches the outputs.
- R6: With `RESET_PROFILE` = 1, reset loads 0x0A into lines A and B and 0x0B into lines C and D.
- R7: Rewriting a routing register moves the line at once. The old target falls if no other active line still feeds it, and the new target rises if the line is active.
- R8: `irq_out` is registered. It changes at the first rising edge after a change of device pins or after the edge that writes a routing register, and not before.
- R9: A shared line is the OR of all device pins that rotate onto it, across devices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dev_int | input | NUM_DEV*4 | Interrupt pin levels, 4 per device, device d at bits 4d+3..4d |
| dev_slot | input | NUM_DEV*2 | Slot number modulo 4 for each device, device d at bits 2d+1..2d |
| cfg_wr | input | 1 | Write strobe for the routing registers |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for `cfg_addr` (combinational) |
| irq_out | output | NUM_IRQ | Legacy interrupt levels |

## Verification
The bench targets lines that share a legacy input. It reroutes one of two lines that feed IRQ 9 and expects IRQ 9 to stay high. A design that recomputed only the moved line's target would drop it there, or would leave a stale bit set once the second line also leaves. Routing values 15, 16 and 0 probe the enable boundary: a design that decodes only the low four bits would wrongly fire IRQ 0 for the value 16. Every device is given a different slot, so a swizzle rotated the wrong way or off by one sends pins to the wrong line. Writes to offsets next to the register window must leave the routing intact. A design that drops the top offset bits would alias onto line A.

// File: rtl/pci_intx_router.sv
module pci_intx_router #(
  parameter int          NUM_DEV       = 4,
  parameter int          NUM_IRQ       = 16,
  parameter int          RESET_PROFILE = 0,
  parameter logic [7:0]  BASE          = 8'h60
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_DEV*4-1:0] dev_int,
  input  logic [NUM_DEV*2-1:0] dev_slot,
  input  logic                 cfg_wr,
  input  logic [7:0]           cfg_addr,
  input  logic [7:0]           cfg_wdata,
  output logic [7:0]           cfg_rdata,
  output logic [NUM_IRQ-1:0]   irq_out
);
  localparam int LINES = 4;

  function automatic logic [7:0] rst_val(int l);
    if (RESET_PROFILE == 1) return (l < 2) ? 8'h0A : 8'h0B;
    return 8'h80;
  endfunction

  logic [7:0]         route_q [LINES];
  logic [LINES*8-1:0] route_flat;
  logic [LINES-1:0]   line_lvl;
  logic [NUM_IRQ-1:0] irq_d;
  logic [1:0]         ln;

  wire win = (cfg_addr[7:2] == BASE[7:2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < LINES; l++) route_q[l] <= rst_val(l);
    end else if (cfg_wr && win) begin
      route_q[cfg_addr[1:0]] <= cfg_wdata;
    end
  end

  assign cfg_rdata = win ? route_q[cfg_addr[1:0]] : 8'h00;

  for (genvar g = 0; g < LINES; g++) begin : g_flat
    assign route_flat[g*8 +: 8] = route_q[g];
  end

  always_comb begin
    line_lvl = '0;
    ln       = '0;
    for (int d = 0; d < NUM_DEV; d++) begin
      for (int p = 0; p < 4; p++) begin
        ln = 2'(p) + dev_slot[d*2 +: 2] + 2'd3;
        if (dev_int[d*4+p]) line_lvl[ln] = 1'b1;
      end
    end
  end

  always_comb begin
    irq_d = '0;
    for (int k = 0; k < NUM_IRQ; k++)
      for (int l = 0; l < LINES; l++)
        if (line_lvl[l] && route_q[l] == 8'(k)) irq_d[k] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_out <= '0;
    else        irq_out <= irq_d;
  end
endmodule

// File: rtl/pci_intx_router_chk.sv
module pci_intx_router_chk #(
  parameter int         NUM_DEV = 4,
  parameter int         NUM_IRQ = 16,
  parameter logic [7:0] BASE    = 8'h60
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_DEV*4-1:0] dev_int,
  input logic [NUM_DEV*2-1:0] dev_slot,
  input logic                 cfg_wr,
  input logic [7:0]           cfg_addr,
  input logic [7:0]           cfg_wdata,
  input logic [31:0]          route_q,
  input logic [NUM_IRQ-1:0]   irq_out
);
  logic [1:0]         up_q;
  logic [NUM_IRQ-1:0] hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          up_q <= '0;
    else if (up_q != 2'd2) up_q <= up_q + 2'd1;
  end

  always_comb begin
    hit = '0;
    for (int k = 0; k < NUM_IRQ; k++)
      for (int l = 0; l < 4; l++)
        if (route_q[l*8 +: 8] == 8'(k)) hit[k] = 1'b1;
  end

  for (genvar i = 0; i < 4; i++) begin : g_wr
    // R2
    reg_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_addr == BASE + 8'(i)) |=> route_q[i*8 +: 8] == $past(cfg_wdata));
  end

  // R2
  off_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr || cfg_addr[7:2] != BASE[7:2]) |=> $stable(route_q));

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_src
    // R3
    irq_has_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out[k] |-> $past(hit[k]));
  end

  // R4
  at_most_four_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(irq_out) <= 4);

  // R5
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> irq_out == '0);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q == 2'd2 && $stable(dev_int) && $stable(dev_slot) && $stable(route_q))
      |=> $stable(irq_out));

  // R8
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q == 2'd2 && $past(dev_int) == '0) |-> irq_out == '0);
endmodule

bind pci_intx_router pci_intx_router_chk #(
  .NUM_DEV(NUM_DEV), .NUM_IRQ(NUM_IRQ), .BASE(BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dev_int(dev_int), .dev_slot(dev_slot),
  .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
  .route_q(route_flat), .irq_out(irq_out)
);

// File: tb/pci_intx_router_tb.sv
module pci_intx_router_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] dev_int = '0;
  logic [7:0]  dev_slot = {2'd0, 2'd3, 2'd2, 2'd1};
  logic        cfg_wr = 0;
  logic [7:0]  cfg_addr = '0, cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic [15:0] irq_out;

  logic [3:0]  a_int = '0;
  logic        a_wr = 0;
  logic [7:0]  a_addr = '0, a_wdata = '0;
  logic [7:0]  a_rdata;
  logic [15:0] a_irq;

  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pci_intx_router u_dut (
    .clk(clk), .rst_n(rst_n), .dev_int(dev_int), .dev_slot(dev_slot),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .irq_out(irq_out));

  pci_intx_router #(.NUM_DEV(1), .RESET_PROFILE(1)) u_alt (
    .clk(clk), .rst_n(rst_n), .dev_int(a_int), .dev_slot(2'd1),
    .cfg_wr(a_wr), .cfg_addr(a_addr), .cfg_wdata(a_wdata),
    .cfg_rdata(a_rdata), .irq_out(a_irq));

  // {dev_int, expected irq_out}; slots d0=1 d1=2 d2=3 d3=0; A->5 B->9 C->9 D off
  localparam logic [31:0] VEC [12] = '{
    {16'h0000, 16'h0000}, {16'h0001, 16'h0020}, {16'h0002, 16'h0200},
    {16'h0008, 16'h0000}, {16'h0010, 16'h0200}, {16'h0080, 16'h0020},
    {16'h0100, 16'h0200}, {16'h0200, 16'h0000}, {16'h1000, 16'h0000},
    {16'h2000, 16'h0020}, {16'h0005, 16'h0220}, {16'hFFFF, 16'h0220}};

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic rd(string tag, logic [7:0] a, logic [7:0] exp);
    @(negedge clk); cfg_addr = a; #1;
    chk(tag, {8'h00, cfg_rdata}, {8'h00, exp});
  endtask

  task automatic drive(logic [15:0] v);
    @(negedge clk); dev_int = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R5 reset state
    chk("R5 irq after reset", irq_out, 16'h0000);
    for (int i = 0; i < 4; i++) rd("R5 route reset", 8'h60 + 8'(i), 8'h80);
    drive(16'hFFFF);
    chk("R5 disabled lines silent", irq_out, 16'h0000);
    drive(16'h0000);

    // R6 alternate profile
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); a_addr = 8'h60 + 8'(i); #1;
      chk("R6 alt route reset", {8'h00, a_rdata}, (i < 2) ? 16'h000A : 16'h000B);
    end
    @(negedge clk); a_int = 4'b0001;
    @(negedge clk);
    chk("R6 alt line A to irq10", a_irq, 16'h0400);
    @(negedge clk); a_int = 4'b0100;
    @(negedge clk);
    chk("R6 alt line C to irq11", a_irq, 16'h0800);

    wr(8'h60, 8'd5); wr(8'h61, 8'd9); wr(8'h62, 8'd9);

    // R1 R3 R4 R9 vector walk, R8 latency on each step
    for (int i = 0; i < 12; i++) begin
      logic [15:0] prev;
      prev = irq_out;
      @(negedge clk); dev_int = VEC[i][31:16]; #1;
      chk("R8 no early change", irq_out, prev);
      @(negedge clk);
      chk("R1 R4 R9 vector", irq_out, VEC[i][15:0]);
    end

    // R2 readback and ignored offsets
    rd("R2 read A", 8'h60, 8'd5);
    rd("R2 read C", 8'h62, 8'd9);
    wr(8'h64, 8'h07); wr(8'h5F, 8'h07); wr(8'hE0, 8'h07);
    rd("R2 outside reads zero", 8'h64, 8'h00);
    rd("R2 A untouched", 8'h60, 8'd5);
    rd("R2 D untouched", 8'h63, 8'h80);
    drive(16'h0001);
    chk("R2 routing intact", irq_out, 16'h0020);

    // R3 boundary values
    wr(8'h60, 8'd15); @(negedge clk);
    chk("R3 value 15", irq_out, 16'h8000);
    wr(8'h60, 8'd16); @(negedge clk);
    chk("R3 value 16 off", irq_out, 16'h0000);
    wr(8'h60, 8'd0); @(negedge clk);
    chk("R3 value 0", irq_out, 16'h0001);

    // R7 reroute with R8 timing
    wr(8'h60, 8'd5); @(negedge clk);
    chk("R7 back to 5", irq_out, 16'h0020);
    wr(8'h60, 8'd7);
    chk("R8 reroute one cycle later", irq_out, 16'h0020);
    @(negedge clk);
    chk("R7 moved to 7", irq_out, 16'h0080);

    // R7 shared target survives
    drive(16'h0006);
    chk("R4 B and C share 9", irq_out, 16'h0200);
    wr(8'h61, 8'd3); @(negedge clk);
    chk("R7 irq9 held by C", irq_out, 16'h0208);
    wr(8'h62, 8'd3); @(negedge clk);
    chk("R7 irq9 released", irq_out, 16'h0008);

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule